// File: doc/BRIEF.md
# Delayed Store Write Buffer

This block sits between a pipelined load/store unit and a data cache with a single data port. A store hands over its word address, data and byte enables, and the block parks them in a small in-order queue. A later tag-check stage reports whether each store hit the cache. Nothing reaches the cache until that result is known, because a cache write cannot be taken back. A store that hit is written only in a cycle when the load path leaves the data port idle. A store that missed is held and flagged until the refill logic acknowledges it.

While a store waits in the queue, loads must not read the stale word from the cache. Every load address is compared against all queued entries. The youngest match decides the outcome. If it covers the whole word, its data is forwarded. If it covers only some bytes, the load is told to stall until the entry drains.

Top module: `dly_store_buf`

## Requirements
- R1: A store is accepted when `st_valid` is high and `st_full` is low. `st_full` is high exactly while DEPTH entries are held. A store offered while `st_full` is high is discarded and never reaches the cache.
- R2: Each tag-check result (`tc_valid`) resolves the oldest unresolved entry. A result that arrives with no unresolved entry is ignored. No cache write occurs for an entry before its result has arrived.
- R3: A resolved hit at the head of the queue drives `wr_en` with its address, data and enables in every cycle that `port_busy` is low, and it leaves the queue at that clock edge. Entries are written in the order they were accepted, one per cycle. While `port_busy` is high, `wr_en` stays low.
- R4: A load (`ld_valid`) whose word address equals that of a queued entry is resolved by the youngest such entry. If that entry's enables are all ones, `fwd_hit` is high and `fwd_data` carries its data in the same cycle.
- R5: If the youngest matching entry has any enable bit low, `ld_stall` is high and `fwd_hit` is low. With no match, both signals are low.
- R6: A miss result marks its entry. While the head entry is marked, `miss_req` is high and that entry is not written. A `miss_ack` clears the mark, and the entry is then written like a hit.
- R7: `wr_be` carries the entry's byte enables (bit k selects byte k, bits 8k+7..8k), so a partial store changes only its enabled bytes. After reset the queue is empty and `st_full`, `wr_en`, `miss_req`, `fwd_hit` and `ld_stall` are low.
- R8: An entry is compared against loads until the clock edge where it is written. After that edge, loads no longer match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_full | output | 1 | Queue full, stores must stall |
| tc_valid | input | 1 | Tag-check result valid for oldest unresolved entry |
| tc_hit | input | 1 | Tag-check result: 1 hit, 0 miss |
| miss_req | output | 1 | Head entry is a recorded miss |
| miss_ack | input | 1 | Refill done for the head miss |
| port_busy | input | 1 | Cache data port in use this cycle |
| wr_en | output | 1 | Cache write strobe |
| wr_addr | output | AW | Cache write word address |
| wr_data | output | DW | Cache write data |
| wr_be | output | DW/8 | Cache write byte enables |
| ld_valid | input | 1 | Load lookup this cycle |
| ld_addr | input | AW | Load word address |
| fwd_hit | output | 1 | Full-word forward from queue |
| fwd_data | output | DW | Forwarded data |
| ld_stall | output | 1 | Partial overlap, load must wait |

## Verification
Load results are combinational. The bench drives the load on the falling edge and reads `fwd_hit`, `ld_stall` and `fwd_data` a few nanoseconds later, before the next rising edge. A store is accepted at the rising edge after it is offered, and its tag result takes effect one edge later. From the following falling edge onward, `wr_en` is due in every cycle with the port free. The checks sample it there, and they sample the next entry one cycle later. The bench's cache model updates on the rising edge where `wr_en` is high, so memory contents are checked at the falling edge after the write. `miss_req` changes at the edge that records the miss, and it drops at the edge that takes the acknowledge.

// File: rtl/dly_store_buf.sv
module dly_store_buf #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  output logic            st_full,
  input  logic            tc_valid,
  input  logic            tc_hit,
  output logic            miss_req,
  input  logic            miss_ack,
  input  logic            port_busy,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [DW/8-1:0] wr_be,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  output logic            fwd_hit,
  output logic [DW-1:0]   fwd_data,
  output logic            ld_stall
);
  localparam int BW = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [BW-1:0]    e_be   [DEPTH];
  logic [DEPTH-1:0] e_vld, e_res, e_miss;
  logic [PW-1:0]    hd, tl, ck;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic push, pop, resolve, ack;

  assign st_full  = (cnt == CW'(DEPTH));
  assign push     = st_valid && !st_full;
  assign resolve  = tc_valid && e_vld[ck] && !e_res[ck];
  assign miss_req = e_vld[hd] && e_miss[hd];
  assign ack      = miss_ack && miss_req;
  assign pop      = e_vld[hd] && e_res[hd] && !e_miss[hd] && !port_busy;

  assign wr_en   = pop;
  assign wr_addr = e_addr[hd];
  assign wr_data = e_data[hd];
  assign wr_be   = e_be[hd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_res  <= '0;
      e_miss <= '0;
      hd     <= '0;
      tl     <= '0;
      ck     <= '0;
      cnt    <= '0;
    end else begin
      if (push) begin
        e_addr[tl] <= st_addr;
        e_data[tl] <= st_data;
        e_be[tl]   <= st_be;
        e_vld[tl]  <= 1'b1;
        e_res[tl]  <= 1'b0;
        e_miss[tl] <= 1'b0;
        tl         <= nxt(tl);
      end
      if (resolve) begin
        e_res[ck]  <= 1'b1;
        e_miss[ck] <= !tc_hit;
        ck         <= nxt(ck);
      end
      if (ack)
        e_miss[hd] <= 1'b0;
      if (pop) begin
        e_vld[hd] <= 1'b0;
        hd        <= nxt(hd);
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  logic          m_found;
  logic [DW-1:0] m_data;
  logic [BW-1:0] m_be;

  always_comb begin
    m_found = 1'b0;
    m_data  = '0;
    m_be    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] j;
      j = PW'((int'(hd) + i) % DEPTH);
      if (e_vld[j] && e_addr[j] == ld_addr) begin
        m_found = 1'b1;
        m_data  = e_data[j];
        m_be    = e_be[j];
      end
    end
  end

  assign fwd_hit  = ld_valid && m_found && (&m_be);
  assign ld_stall = ld_valid && m_found && !(&m_be);
  assign fwd_data = m_data;
endmodule

// File: rtl/dly_store_buf_chk.sv
module dly_store_buf_chk #(
  parameter int DEPTH = 2
) (
  input logic clk,
  input logic rst_n,
  input logic st_valid,
  input logic st_full,
  input logic tc_valid,
  input logic tc_hit,
  input logic miss_req,
  input logic miss_ack,
  input logic port_busy,
  input logic wr_en,
  input logic ld_valid,
  input logic fwd_hit,
  input logic ld_stall
);
  logic [15:0] n_acc, n_res, n_ok, n_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_acc <= '0;
      n_res <= '0;
      n_ok  <= '0;
      n_wr  <= '0;
    end else begin
      n_acc <= n_acc + 16'(st_valid && !st_full);
      n_res <= n_res + 16'(tc_valid && (n_res < n_acc));
      n_ok  <= n_ok + 16'(tc_valid && tc_hit && (n_res < n_acc))
                    + 16'(miss_ack && miss_req);
      n_wr  <= n_wr + 16'(wr_en);
    end
  end

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (n_acc - n_wr) <= 16'(DEPTH));
  a_r1_full_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_full) |-> $past(wr_en));
  a_r2_write_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (n_wr < n_ok));
  a_r3_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !port_busy);
  a_r4_load_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit || ld_stall) |-> ld_valid);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_hit && ld_stall));
  a_r6_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> !wr_en);
  a_r6_miss_held: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !miss_ack) |=> miss_req);
endmodule

bind dly_store_buf dly_store_buf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_dly_store_buf.sv
module test_dly_store_buf;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, tc_valid = 0, tc_hit = 0, miss_ack = 0, port_busy = 0, ld_valid = 0;
  logic [15:0] st_addr = 0, ld_addr = 0;
  logic [31:0] st_data = 0;
  logic [3:0]  st_be = 0;
  logic st_full, miss_req, wr_en, fwd_hit, ld_stall;
  logic [15:0] wr_addr;
  logic [31:0] wr_data, fwd_data;
  logic [3:0]  wr_be;
  logic [31:0] mem [256];
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  dly_store_buf i_dly_store_buf (.*);

  always @(posedge clk)
    if (wr_en)
      for (int k = 0; k < 4; k++)
        if (wr_be[k]) mem[wr_addr[7:0]][8*k +: 8] <= wr_data[8*k +: 8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic tag(input logic hit);
    @(negedge clk);
    tc_valid = 1; tc_hit = hit;
    @(negedge clk);
    tc_valid = 0;
  endtask

  task automatic look(input logic [15:0] a);
    ld_valid = 1; ld_addr = a; #2;
  endtask

  task automatic t_reset;
    #2;
    chk("R7 reset st_full", 32'(st_full), 0);
    chk("R7 reset wr_en", 32'(wr_en), 0);
    chk("R7 reset miss_req", 32'(miss_req), 0);
    look(16'h10);
    chk("R7 reset fwd_hit", 32'(fwd_hit), 0);
    chk("R7 reset ld_stall", 32'(ld_stall), 0);
    ld_valid = 0;
  endtask

  task automatic t_basic;
    port_busy = 1;
    push(16'h10, 32'hCAFE0001, 4'hF);
    tag(1);
    #2 chk("R3 busy holds write", 32'(wr_en), 0);
    look(16'h10);
    chk("R4 forward hit", 32'(fwd_hit), 1);
    chk("R4 forward data", fwd_data, 32'hCAFE0001);
    ld_valid = 0;
    @(negedge clk); port_busy = 0; #2;
    chk("R3 write when free", 32'(wr_en), 1);
    chk("R3 write addr", 32'(wr_addr), 32'h10);
    look(16'h10);
    chk("R8 snoop until written", 32'(fwd_hit), 1);
    ld_valid = 0;
    @(negedge clk); #2;
    look(16'h10);
    chk("R8 no match after write", 32'(fwd_hit), 0);
    ld_valid = 0;
    chk("R3 cache updated", mem[8'h10], 32'hCAFE0001);
  endtask

  task automatic t_no_early;
    tag(1);
    push(16'h20, 32'h00002222, 4'hF);
    repeat (3) begin
      @(negedge clk); #2;
      chk("R2 no write before tag", 32'(wr_en), 0);
    end
    tag(1);
    #2 chk("R2 write after tag", 32'(wr_en), 1);
    @(negedge clk); #2;
    chk("R2 cache after tag", mem[8'h20], 32'h00002222);
  endtask

  task automatic t_full;
    port_busy = 1;
    push(16'h30, 32'h33330000, 4'hF);
    push(16'h31, 32'h33331111, 4'hF);
    #2 chk("R1 full at depth", 32'(st_full), 1);
    push(16'h32, 32'h33332222, 4'hF);
    tag(1);
    tag(1);
    @(negedge clk); port_busy = 0; #2;
    chk("R3 fifo first", 32'(wr_addr), 32'h30);
    @(negedge clk); #2;
    chk("R3 fifo second", 32'(wr_addr), 32'h31);
    chk("R3 second write", 32'(wr_en), 1);
    @(negedge clk); #2;
    chk("R3 drained", 32'(wr_en), 0);
    chk("R1 not full", 32'(st_full), 0);
    chk("R1 dropped store", mem[8'h32], 0);
    chk("R1 first stored", mem[8'h30], 32'h33330000);
  endtask

  task automatic t_youngest;
    port_busy = 1;
    push(16'h40, 32'h0000AAAA, 4'hF);
    push(16'h40, 32'h0000BBBB, 4'hF);
    look(16'h40);
    chk("R4 youngest data", fwd_data, 32'h0000BBBB);
    ld_valid = 0;
    tag(1); tag(1);
    @(negedge clk); port_busy = 0;
    repeat (2) @(negedge clk);
    #2 chk("R3 order final", mem[8'h40], 32'h0000BBBB);
  endtask

  task automatic t_partial;
    port_busy = 1;
    push(16'h50, 32'h12345678, 4'b0011);
    look(16'h50);
    chk("R5 partial stall", 32'(ld_stall), 1);
    chk("R5 partial no fwd", 32'(fwd_hit), 0);
    look(16'h51);
    chk("R5 no match stall", 32'(ld_stall), 0);
    chk("R5 no match fwd", 32'(fwd_hit), 0);
    ld_valid = 0;
    tag(1);
    @(negedge clk); port_busy = 0; #2;
    chk("R7 write enables", 32'(wr_be), 32'h3);
    @(negedge clk); #2;
    chk("R7 partial write", mem[8'h50], 32'hAAAA5678);
  endtask

  task automatic t_miss;
    push(16'h60, 32'h66666666, 4'hF);
    tag(0);
    #2 chk("R6 miss raised", 32'(miss_req), 1);
    repeat (2) begin
      @(negedge clk); #2;
      chk("R6 miss held no write", 32'(wr_en), 0);
    end
    chk("R6 still raised", 32'(miss_req), 1);
    @(negedge clk); miss_ack = 1;
    @(negedge clk); miss_ack = 0; #2;
    chk("R6 miss cleared", 32'(miss_req), 0);
    chk("R6 write after ack", 32'(wr_en), 1);
    @(negedge clk); #2;
    chk("R6 cache after ack", mem[8'h60], 32'h66666666);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    mem[8'h50] = 32'hAAAAAAAA;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_no_early;
    t_full;
    t_youngest;
    t_partial;
    t_miss;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule